// File: doc/BRIEF.md
# Card Security Level Controller

This block holds the security level of a contactless card whose cipher is being migrated from a legacy scheme to AES. It tracks the active level (0 to 3), keeps one sticky flag per mandatory personalisation key, and acts on two kinds of request. A commit request ends personalisation. A switch request, which a separate authentication engine has already vetted, raises the level further. From the level it derives the permission flags that the protocol front ends use. Those flags say whether legacy-protocol frames may be accepted and which command classes the block-transmission protocol may run.

Level and key flags are registers. While reset is held they load a value taken from non-volatile storage, so that a card resumes at its saved level after each power-up. The level can only go up. An accepted request takes effect at the next clock edge. A refused request changes nothing and produces a single-cycle error pulse. All pins are plain control and status signals. There is no data stream, and so no valid/ready handshake.

Top module: `seclvl_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the level loads `nv_level_i` and the key flags load `nv_keys_i`. `err_o` is 0 after reset.
- R2: When `card_l3_i` is 1 and `nv_level_i` is 1 or 2, reset loads level 3 instead. A card strapped for level 3 never shows level 1 or 2.
- R3: An accepted commit moves level 0 to level 1 when `card_l3_i`=0, and to level 3 when `card_l3_i`=1.
- R4: Key identifiers: 0 is the card configuration key, 1 the card master key, 2 the level-2 switch key, 3 the level-3 switch key. A commit is accepted only at level 0 and only when the required flags are set. Keys 0 and 1 are always required. Keys 2 and 3 are also required when `card_l3_i`=0.
- R5: A `key_wr_i` pulse sets the flag of `key_id_i` at the next edge. An identifier of `N_KEYS` or more has no effect. A commit in the same cycle still sees the old flags.
- R6: A switch request is accepted only at level 1 or higher, and only when `sw_tgt_i` is greater than the current level. A request for a lower or equal level is refused.
- R7: A switch request is accepted only when `sw_auth_ok_i` is 1 in the same cycle. On an L3-strapped card only target 3 is acceptable.
- R8: `commit_i` and `sw_req_i` high in the same cycle are refused together.
- R9: A refused request leaves the level unchanged. It sets `err_o` for exactly the one cycle that follows the request edge.
- R10: `legacy_en_o` is 1 at levels 0, 1 and 2, and 0 at level 3.
- R11: `blk_full_en_o` is 1 at levels 0 and 3. `blk_keycfg_en_o` (AES key and configuration updates) is 1 at levels 0, 2 and 3. Level switching and the originality check are allowed at every level, so they need no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, loads stored values |
| nv_level_i | input | 2 | Stored level loaded during reset |
| nv_keys_i | input | N_KEYS | Stored key-written flags loaded during reset |
| card_l3_i | input | 1 | Strap: 1 = L3 card, 0 = L1 card |
| key_wr_i | input | 1 | Key-written strobe |
| key_id_i | input | KEY_ID_W | Identifier of the key written |
| commit_i | input | 1 | Commit personalisation request |
| sw_req_i | input | 1 | Level switch request |
| sw_tgt_i | input | 2 | Target level of the switch |
| sw_auth_ok_i | input | 1 | Switch-key authentication passed |
| level_o | output | 2 | Current security level |
| legacy_en_o | output | 1 | Legacy protocol allowed |
| blk_full_en_o | output | 1 | Full block-transmission command set allowed |
| blk_keycfg_en_o | output | 1 | AES key / configuration update commands allowed |
| err_o | output | 1 | One-cycle pulse for a refused request |

## Verification
A request or key strobe that is sampled at one rising edge updates `level_o`, the key flags and `err_o` at that same edge. The bench therefore drives its inputs at a falling edge and compares them at the next falling edge, half a cycle after the update. The permission flags are decoded combinationally from the level register. They are due in the same cycle as the new level and are compared at that same point. Key flags can only be seen through a later commit, so each key check uses a commit one cycle after the key strobe.

// File: rtl/seclvl_pkg.sv
package seclvl_pkg;
  localparam int LVL_W = 2;
  typedef logic [LVL_W-1:0] lvl_t;

  localparam lvl_t LVL_PERSO  = 2'd0;
  localparam lvl_t LVL_COMPAT = 2'd1;
  localparam lvl_t LVL_MIXED  = 2'd2;
  localparam lvl_t LVL_AES    = 2'd3;

  localparam int KEY_CFG  = 0;
  localparam int KEY_MST  = 1;
  localparam int KEY_SW2  = 2;
  localparam int KEY_SW3  = 3;
  localparam int N_MAND   = 4;
endpackage

// File: rtl/seclvl_keyflags.sv
module seclvl_keyflags #(
  parameter int N_KEYS   = 4,
  parameter int KEY_ID_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_KEYS-1:0]   nv_keys_i,
  input  logic                key_wr_i,
  input  logic [KEY_ID_W-1:0] key_id_i,
  output logic [N_KEYS-1:0]   flags_o
);
  for (genvar k = 0; k < N_KEYS; k++) begin : g_flag
    logic hit;
    assign hit = key_wr_i && (key_id_i == KEY_ID_W'(k));
    always_ff @(posedge clk) begin
      if (!rst_n)   flags_o[k] <= nv_keys_i[k];
      else if (hit) flags_o[k] <= 1'b1;
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_o & $past(flags_o)) == $past(flags_o))); // R5
endmodule

// File: rtl/seclvl_fsm.sv
module seclvl_fsm
  import seclvl_pkg::*;
#(
  parameter int N_KEYS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  lvl_t              nv_level_i,
  input  logic              card_l3_i,
  input  logic [N_KEYS-1:0] flags_i,
  input  logic              commit_i,
  input  logic              sw_req_i,
  input  lvl_t              sw_tgt_i,
  input  logic              sw_auth_ok_i,
  output lvl_t              level_o,
  output logic              err_o
);
  logic [N_MAND-1:0] need;
  logic              keys_ok;
  logic              commit_ok, sw_ok, conflict;
  lvl_t              lvl_q, lvl_d, commit_tgt, boot_lvl;
  logic              err_d;

  always_comb begin
    need = '0;
    need[KEY_CFG] = 1'b1;
    need[KEY_MST] = 1'b1;
    need[KEY_SW2] = !card_l3_i;
    need[KEY_SW3] = !card_l3_i;
  end

  assign keys_ok    = &(flags_i[N_MAND-1:0] | ~need);
  assign commit_tgt = card_l3_i ? LVL_AES : LVL_COMPAT;
  assign conflict   = commit_i && sw_req_i;
  assign commit_ok  = (lvl_q == LVL_PERSO) && keys_ok;
  assign sw_ok      = (lvl_q != LVL_PERSO) && (sw_tgt_i > lvl_q) && sw_auth_ok_i
                      && !(card_l3_i && (sw_tgt_i != LVL_AES));

  always_comb begin
    boot_lvl = nv_level_i;
    if (card_l3_i && (nv_level_i == LVL_COMPAT || nv_level_i == LVL_MIXED))
      boot_lvl = LVL_AES;
  end

  always_comb begin
    lvl_d = lvl_q;
    err_d = 1'b0;
    if (conflict) begin
      err_d = 1'b1;
    end else if (commit_i) begin
      if (commit_ok) lvl_d = commit_tgt;
      else           err_d = 1'b1;
    end else if (sw_req_i) begin
      if (sw_ok) lvl_d = sw_tgt_i;
      else       err_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= boot_lvl;
      err_o <= 1'b0;
    end else begin
      lvl_q <= lvl_d;
      err_o <= err_d;
    end
  end

  assign level_o = lvl_q;

  AST_NO_DOWNGRADE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (lvl_q >= $past(lvl_q))); // R6
  AST_ERR_HOLDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_req_i || commit_i) && !(commit_ok && !sw_req_i) && !(sw_ok && !commit_i)
    |=> err_o && $stable(lvl_q)); // R9
  AST_COMMIT_KEYS: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i && !sw_req_i && (lvl_q == LVL_PERSO) && !flags_i[KEY_MST] |=> (lvl_q == LVL_PERSO)); // R4
  AST_SWITCH_AUTH: assert property (@(posedge clk) disable iff (!rst_n)
    sw_req_i && !sw_auth_ok_i |=> $stable(lvl_q)); // R7
  AST_L3_NO_MID: assert property (@(posedge clk) disable iff (!rst_n)
    card_l3_i && $stable(card_l3_i) |-> !(lvl_q == LVL_COMPAT || lvl_q == LVL_MIXED)); // R2
endmodule

// File: rtl/seclvl_perm.sv
module seclvl_perm
  import seclvl_pkg::*;
(
  input  lvl_t level_i,
  output logic legacy_en_o,
  output logic blk_full_en_o,
  output logic blk_keycfg_en_o
);
  always_comb begin
    legacy_en_o     = 1'b0;
    blk_full_en_o   = 1'b0;
    blk_keycfg_en_o = 1'b0;
    unique case (level_i)
      LVL_PERSO: begin
        legacy_en_o     = 1'b1;
        blk_full_en_o   = 1'b1;
        blk_keycfg_en_o = 1'b1;
      end
      LVL_COMPAT: legacy_en_o = 1'b1;
      LVL_MIXED: begin
        legacy_en_o     = 1'b1;
        blk_keycfg_en_o = 1'b1;
      end
      default: begin
        blk_full_en_o   = 1'b1;
        blk_keycfg_en_o = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/seclvl_ctrl.sv
module seclvl_ctrl
  import seclvl_pkg::*;
#(
  parameter int N_KEYS   = 4,
  parameter int KEY_ID_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          nv_level_i,
  input  logic [N_KEYS-1:0]   nv_keys_i,
  input  logic                card_l3_i,
  input  logic                key_wr_i,
  input  logic [KEY_ID_W-1:0] key_id_i,
  input  logic                commit_i,
  input  logic                sw_req_i,
  input  logic [1:0]          sw_tgt_i,
  input  logic                sw_auth_ok_i,
  output logic [1:0]          level_o,
  output logic                legacy_en_o,
  output logic                blk_full_en_o,
  output logic                blk_keycfg_en_o,
  output logic                err_o
);
  logic [N_KEYS-1:0] flags;
  lvl_t              lvl;

  seclvl_keyflags #(.N_KEYS(N_KEYS), .KEY_ID_W(KEY_ID_W)) u_keys (
    .clk(clk), .rst_n(rst_n), .nv_keys_i(nv_keys_i),
    .key_wr_i(key_wr_i), .key_id_i(key_id_i), .flags_o(flags));

  seclvl_fsm #(.N_KEYS(N_KEYS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .nv_level_i(nv_level_i), .card_l3_i(card_l3_i),
    .flags_i(flags), .commit_i(commit_i), .sw_req_i(sw_req_i),
    .sw_tgt_i(sw_tgt_i), .sw_auth_ok_i(sw_auth_ok_i),
    .level_o(lvl), .err_o(err_o));

  seclvl_perm u_perm (
    .level_i(lvl), .legacy_en_o(legacy_en_o),
    .blk_full_en_o(blk_full_en_o), .blk_keycfg_en_o(blk_keycfg_en_o));

  assign level_o = lvl;

  AST_LEGACY_OFF_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(level_o == LVL_AES) |-> !legacy_en_o); // R10
endmodule

// File: tb/tb_seclvl_ctrl.sv
module tb_seclvl_ctrl;
  localparam int N_KEYS = 4;
  localparam int KEY_ID_W = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, card_l3, key_wr, commit, sw_req, sw_auth;
  logic [1:0] nv_level, sw_tgt;
  logic [N_KEYS-1:0] nv_keys;
  logic [KEY_ID_W-1:0] key_id;
  logic [1:0] level;
  logic legacy_en, blk_full, blk_keycfg, err;

  seclvl_ctrl #(.N_KEYS(N_KEYS), .KEY_ID_W(KEY_ID_W)) dut (
    .clk(clk), .rst_n(rst_n), .nv_level_i(nv_level), .nv_keys_i(nv_keys),
    .card_l3_i(card_l3), .key_wr_i(key_wr), .key_id_i(key_id),
    .commit_i(commit), .sw_req_i(sw_req), .sw_tgt_i(sw_tgt),
    .sw_auth_ok_i(sw_auth), .level_o(level), .legacy_en_o(legacy_en),
    .blk_full_en_o(blk_full), .blk_keycfg_en_o(blk_keycfg), .err_o(err));

  int checks = 0;
  int failures = 0;
  logic [1:0] m_lvl;
  logic [N_KEYS-1:0] m_keys;
  logic m_err;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] boot_level(input logic [1:0] nv, input logic l3);
    if (l3 && (nv == 2'd1 || nv == 2'd2)) return 2'd3;
    return nv;
  endfunction

  // expected model of one clock edge
  task automatic model_edge();
    logic need_ok;
    logic [1:0] nl;
    logic ne;
    need_ok = m_keys[0] && m_keys[1] && (card_l3 || (m_keys[2] && m_keys[3]));
    nl = m_lvl; ne = 1'b0;
    if (commit && sw_req) ne = 1'b1;
    else if (commit) begin
      if (m_lvl == 2'd0 && need_ok) nl = card_l3 ? 2'd3 : 2'd1;
      else ne = 1'b1;
    end else if (sw_req) begin
      if (m_lvl != 2'd0 && sw_tgt > m_lvl && sw_auth && !(card_l3 && sw_tgt != 2'd3))
        nl = sw_tgt;
      else ne = 1'b1;
    end
    if (key_wr && key_id < KEY_ID_W'(N_KEYS)) m_keys[key_id[1:0]] = 1'b1;
    m_lvl = nl; m_err = ne;
  endtask

  task automatic check_outputs(input string tag);
    chk(level == m_lvl, tag, level, m_lvl);
    chk(err == m_err, "R9 err", err, m_err);
    chk(legacy_en == (m_lvl != 2'd3), "R10 legacy", legacy_en, m_lvl != 2'd3);
    chk(blk_full == (m_lvl == 2'd0 || m_lvl == 2'd3), "R11 full", blk_full,
        m_lvl == 2'd0 || m_lvl == 2'd3);
    chk(blk_keycfg == (m_lvl != 2'd1), "R11 keycfg", blk_keycfg, m_lvl != 2'd1);
  endtask

  task automatic idle();
    key_wr = 0; key_id = '0; commit = 0; sw_req = 0; sw_tgt = 0; sw_auth = 0;
  endtask

  task automatic do_reset(input logic [1:0] nvl, input logic [N_KEYS-1:0] nvk, input logic l3);
    idle();
    nv_level = nvl; nv_keys = nvk; card_l3 = l3; rst_n = 0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rst_n = 1;
    m_lvl = boot_level(nvl, l3); m_keys = nvk; m_err = 0;
  endtask

  task automatic step(input logic kw, input logic [KEY_ID_W-1:0] kid, input logic cm,
                      input logic sr, input logic [1:0] st, input logic sa, input string tag);
    key_wr = kw; key_id = kid; commit = cm; sw_req = sr; sw_tgt = st; sw_auth = sa;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    idle();
    check_outputs(tag);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20251));
    // R1 reset preset
    do_reset(2'd2, 4'b1010, 1'b0);
    check_outputs("R1 reset level");
    // R2 L3 strap sanitises stored level 1
    do_reset(2'd1, 4'b0000, 1'b1);
    check_outputs("R2 L3 boot");
    // L1 card personalisation
    do_reset(2'd0, 4'b0000, 1'b0);
    step(0, 0, 1, 0, 0, 0, "R4 commit no keys");
    step(1, 3'd0, 0, 0, 0, 0, "R5 key cfg");
    step(1, 3'd1, 0, 0, 0, 0, "R5 key mst");
    step(1, 3'd2, 0, 0, 0, 0, "R5 key sw2");
    step(1, 3'd7, 0, 0, 0, 0, "R5 out of range id");
    step(0, 0, 1, 0, 0, 0, "R5 id 7 ignored, commit refused");
    step(1, 3'd3, 1, 0, 0, 0, "R5 commit sees old flags");
    step(0, 0, 1, 1, 2'd2, 1, "R8 simultaneous");
    step(0, 0, 1, 0, 0, 0, "R3 commit L1 to 1");
    step(0, 0, 0, 1, 2'd1, 1, "R6 equal target");
    step(0, 0, 0, 1, 2'd3, 0, "R7 no auth");
    step(0, 0, 0, 1, 2'd2, 1, "R7 switch to 2");
    step(0, 0, 0, 1, 2'd1, 1, "R6 downgrade");
    step(0, 0, 1, 0, 0, 0, "R4 commit after level 0");
    step(0, 0, 0, 1, 2'd3, 1, "R6 switch to 3");
    step(0, 0, 0, 0, 0, 0, "R9 pulse clears");
    // L3 card: two keys enough, goes straight to 3
    do_reset(2'd0, 4'b0001, 1'b1);
    step(0, 0, 0, 1, 2'd3, 1, "R6 switch from level 0");
    step(1, 3'd1, 0, 0, 0, 0, "R5 key mst L3");
    step(0, 0, 1, 0, 0, 0, "R3 commit L3 to 3");
    // random phases
    for (int ph = 0; ph < 40; ph++) begin
      do_reset(2'($urandom_range(0, 3)), 4'($urandom), 1'($urandom));
      check_outputs("R1 random reset");
      for (int i = 0; i < 200; i++) begin
        step($urandom_range(0, 3) == 0, 3'($urandom), $urandom_range(0, 9) == 0,
             $urandom_range(0, 7) == 0, 2'($urandom), 1'($urandom), "R6 random level");
      end
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule